// File: doc/BRIEF.md
# Three-Wire Serial Register Port (Peripheral Side)

This block is the peripheral end of a control port that uses three wires: an active-low select, a serial clock from the host, and one data line that both sides share. The host sends 16-clock frames, most significant bit first. Each frame holds a direction flag, a 6-bit register address, one idle slot, and 8 data bits. Write frames land in an internal 64 x 8 register file, and the block also exports a one-cycle write strobe carrying the address and data. In a read frame the block takes over the data line after the address and shifts the addressed register back out to the host.

All logic runs on a fast system clock. The select, serial clock and incoming data pass together through a two-stage synchroniser, and serial clock edges are found by comparing successive synchronised samples. The shared data line is modelled as a separate input, output and output enable, so the pad ring can build the tri-state buffer.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset the output enable and the write strobe are low, and every register reads back as 0x00.
- R2: A frame carries 16 bits, most significant bit first: direction flag, address bits 5 down to 0, one idle bit, data bits 7 down to 0. A direction flag of 0 means write and 1 means read.
- R3: A write frame changes the addressed register only on the 16th rising serial clock edge. At that point the write strobe is high for exactly one system clock, with the frame's address and data on the address and data outputs.
- R4: If select goes high before the 16th rising edge of a write frame, the frame is dropped: no strobe, and no register changes.
- R5: While select stays low, write frames may follow each other directly. Each run of 16 rising edges is a separate write.
- R6: In a read frame the address is complete on the 7th rising edge. The output enable rises on the next falling edge (the idle slot, where the value is meaningless). Falling edges 2 to 9 after the address then drive data bits 7 down to 0 of the addressed register.
- R7: After a read frame, all further serial clocks are ignored until select goes high. The output enable stays on until then, no write happens, and no register changes.
- R8: The output enable is low whenever select is high (after the synchroniser delay) and during write frames. It never coincides with the write strobe.
- R9: The write strobe is never high for two system clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen from the pad |
| sdio_o | output | 1 | Data driven toward the pad during reads |
| sdio_oe_o | output | 1 | Pad driver enable for the data line |
| wr_stb_o | output | 1 | One-cycle pulse per completed write frame |
| wr_addr_o | output | 6 | Register address of the completed write |
| wr_data_o | output | 8 | Data of the completed write |

## Verification
The register file is swept completely several times. First every address is read right after reset. Then every address is written with an address-dependent pattern and read back, and then with a second, walking-bit pattern. This separates address decoding faults from faults in the bit order or bit alignment of the data path. Chained writes within one select window show whether each group of 16 clocks is framed on its own. A frame cut off after 15 bits shows whether completion is tied to exactly the 16th edge. A write pattern clocked after a read in the same window shows whether the block really stops listening after a read. Output enable is observed during every write bit, every read slot and after select rises, which shows that line turnaround is tied to the read phase alone.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Phases of one select window.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,   // collecting direction flag and address
        PH_DATA = 2'd1,   // collecting idle bit and write data
        PH_READ = 2'd2,   // driving read data on falling edges
        PH_HALT = 2'd3    // read done, deaf until select rises
    } phase_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= RST_VAL;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/tw_frame.sv
module tw_frame
    import tw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s_i,
    input  logic              sclk_s_i,
    input  logic              din_s_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wstb_o,
    output logic              dout_o,
    output logic              oe_o
);

    localparam int HDR_LEN   = 1 + ADDR_W;
    localparam int FRAME_LEN = HDR_LEN + 1 + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    // Bits kept before the last one arrives: address, idle bit, data minus one.
    localparam int SH_W      = ADDR_W + DATA_W;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [SH_W-1:0]    shreg;
        logic               sclk_prev;
        logic               stb;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [DATA_W-1:0]  rdbuf;
        logic [CNT_W-1:0]   rd_slot;
        logic               oe;
        logic               dout;
    } frame_t;

    frame_t st_d, st_q;
    logic   rise, fall;

    always_comb begin
        st_d           = st_q;
        st_d.stb       = 1'b0;
        st_d.sclk_prev = sclk_s_i;
        rise           = sclk_s_i & ~st_q.sclk_prev;
        fall           = ~sclk_s_i & st_q.sclk_prev;

        if (csn_s_i) begin
            st_d.phase   = PH_HDR;
            st_d.cnt     = '0;
            st_d.rd_slot = '0;
            st_d.oe      = 1'b0;
            st_d.dout    = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_HDR: begin
                    if (rise) begin
                        st_d.shreg = {st_q.shreg[SH_W-2:0], din_s_i};
                        st_d.cnt   = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(HDR_LEN - 1)) begin
                            if (st_q.shreg[ADDR_W-1]) begin
                                st_d.addr    = {st_q.shreg[ADDR_W-2:0], din_s_i};
                                st_d.phase   = PH_READ;
                                st_d.rd_slot = '0;
                            end else begin
                                st_d.phase = PH_DATA;
                            end
                        end
                    end
                end
                PH_DATA: begin
                    if (rise) begin
                        st_d.shreg = {st_q.shreg[SH_W-2:0], din_s_i};
                        st_d.cnt   = st_q.cnt + 1'b1;
                        if (st_q.cnt == CNT_W'(FRAME_LEN - 1)) begin
                            st_d.stb   = 1'b1;
                            st_d.addr  = st_q.shreg[SH_W-1 -: ADDR_W];
                            st_d.data  = {st_q.shreg[DATA_W-2:0], din_s_i};
                            st_d.cnt   = '0;
                            st_d.phase = PH_HDR;
                        end
                    end
                end
                PH_READ: begin
                    if (fall) begin
                        st_d.oe      = 1'b1;
                        st_d.rd_slot = st_q.rd_slot + 1'b1;
                        if (st_q.rd_slot == '0) begin
                            st_d.rdbuf = rdata_i;
                            st_d.dout  = 1'b0;
                        end else begin
                            st_d.dout  = st_q.rdbuf[DATA_W-1];
                            st_d.rdbuf = {st_q.rdbuf[DATA_W-2:0], 1'b0};
                        end
                        if (st_q.rd_slot == CNT_W'(DATA_W)) begin
                            st_d.phase = PH_HALT;
                        end
                    end
                end
                PH_HALT: begin
                    st_d.phase = PH_HALT;
                end
                default: begin
                    st_d.phase = PH_HDR;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.phase     <= PH_HDR;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.data;
    assign wstb_o  = st_q.stb;
    assign dout_o  = st_q.dout;
    assign oe_o    = st_q.oe;

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    // Bit order inside the synchronised bundle.
    localparam int B_CSN  = 2;
    localparam int B_SCLK = 1;
    localparam int B_DATA = 0;

    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              wstb;

    tw_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_n_i, sclk_i, sdio_i}),
        .sync_o  (pins_s)
    );

    tw_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_s_i  (pins_s[B_CSN]),
        .sclk_s_i (pins_s[B_SCLK]),
        .din_s_i  (pins_s[B_DATA]),
        .rdata_i  (rdata),
        .addr_o   (addr),
        .wdata_o  (wdata),
        .wstb_o   (wstb),
        .dout_o   (sdio_o),
        .oe_o     (sdio_oe_o)
    );

    tw_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wstb),
        .waddr_i (addr),
        .wdata_i (wdata),
        .raddr_i (addr),
        .rdata_o (rdata)
    );

    assign wr_stb_o  = wstb;
    assign wr_addr_o = addr;
    assign wr_data_o = wdata;

endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n_i,
    input logic sdio_oe_o,
    input logic wr_stb_o
);

    // Select reaches the frame logic two flops late, its outputs one flop later.
    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe_o |-> !$past(sel_n_i, 3)); // R8

    AST_STB_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !sdio_oe_o); // R8

    AST_STB_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !$past(sel_n_i, 3)); // R4

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R9

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe_o) |-> $past(sel_n_i, 3)); // R7

endmodule

bind tw_reg_slave tw_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_i   (sel_n_i),
    .sdio_oe_o (sdio_oe_o),
    .wr_stb_o  (wr_stb_o)
);

// File: tb/tw_reg_slave_test.sv
module tw_reg_slave_test;

    localparam int HP = 8;   // serial half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       sdout, oe, stb;
    logic [5:0] waddr;
    logic [7:0] wdata;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    int oe_in_write = 0;
    int stb_long = 0;
    bit in_write = 1'b0;
    bit done = 1'b0;
    logic       prev_stb = 1'b0;
    logic [5:0] last_a;
    logic [7:0] last_d;
    logic [7:0] model [64];

    always #10 clk = ~clk;

    tw_reg_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_i   (sel_n),
        .sclk_i    (sclk),
        .sdio_i    (sdin),
        .sdio_o    (sdout),
        .sdio_oe_o (oe),
        .wr_stb_o  (stb),
        .wr_addr_o (waddr),
        .wr_data_o (wdata)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (stb) begin
                stb_cnt++;
                last_a = waddr;
                last_d = wdata;
            end
            if (stb && prev_stb) stb_long++;
            prev_stb = stb;
            if (in_write && oe) oe_in_write++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sclk = 1'b0;
        sdin = b;
        tick(HP);
        sclk = 1'b1;
        tick(HP);
    endtask

    task automatic cs_on();
        sel_n = 1'b0;
        tick(HP);
    endtask

    task automatic cs_off();
        sel_n = 1'b1;
        tick(4 * HP);
        sclk = 1'b0;
        tick(HP);
    endtask

    task automatic wr_frame(input logic [5:0] a, input logic [7:0] d);
        logic [15:0] w;
        w = {1'b0, a, 1'b0, d};
        for (int i = 15; i >= 0; i--) sbit(w[i]);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        in_write = 1'b1;
        cs_on();
        wr_frame(a, d);
        cs_off();
        in_write = 1'b0;
        model[a] = d;
    endtask

    // Leaves select low; the caller ends the window.
    task automatic rd_frame(input logic [5:0] a, output logic [7:0] v, output bit oe_ok);
        logic [6:0] h;
        h = {1'b1, a};
        v = '0;
        oe_ok = 1'b1;
        cs_on();
        for (int i = 6; i >= 0; i--) sbit(h[i]);
        for (int s = 0; s < 9; s++) begin
            sclk = 1'b0;
            sdin = 1'b0;
            tick(HP);
            if (oe !== 1'b1) oe_ok = 1'b0;
            if (s > 0) v = {v[6:0], sdout};
            sclk = 1'b1;
            tick(HP);
        end
    endtask

    task automatic read_sweep(input string req);
        logic [7:0] v;
        bit ok;
        int errs;
        errs = 0;
        for (int a = 0; a < 64; a++) begin
            rd_frame(6'(a), v, ok);
            cs_off();
            if (v !== model[a] || !ok) begin
                errs++;
                $display("FAIL %s addr=%0d actual=%0h expected=%0h oe_ok=%0d",
                         req, a, v, model[a], ok);
            end
        end
        total++;
        if (errs != 0) bad++;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit ok;
        int base;
        for (int a = 0; a < 64; a++) model[a] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: idle outputs and cleared registers
        check("R1 oe after reset", oe, 0);
        check("R1 strobe after reset", stb, 0);
        read_sweep("R1 read after reset");

        // R2 R3: sweep of writes with an arithmetic pattern
        for (int a = 0; a < 64; a++) begin
            base = stb_cnt;
            do_write(6'(a), 8'((a * 37 + 5) & 255));
            if (a % 16 == 3) begin
                check("R3 one strobe per frame", stb_cnt - base, 1);
                check("R3 strobe address", last_a, a);
                check("R2 strobe data", last_d, (a * 37 + 5) & 255);
            end
        end
        check("R3 total strobes", stb_cnt, 64);
        read_sweep("R6 readback pattern A");

        // R2: walking-bit pattern separates bit-order faults
        for (int a = 0; a < 64; a++) do_write(6'(a), 8'((1 << (a % 8)) ^ a));
        read_sweep("R2 readback pattern B");

        // R5: four chained writes in one select window
        base = stb_cnt;
        in_write = 1'b1;
        cs_on();
        for (int k = 0; k < 4; k++) begin
            wr_frame(6'(40 + k), 8'(8'hA0 + k * 17));
            model[40 + k] = 8'(8'hA0 + k * 17);
        end
        cs_off();
        in_write = 1'b0;
        check("R5 chained strobes", stb_cnt - base, 4);
        check("R5 last chained address", last_a, 43);
        for (int k = 0; k < 4; k++) begin
            rd_frame(6'(40 + k), v, ok);
            cs_off();
            check("R5 chained readback", v, model[40 + k]);
        end

        // R4: write cut off after 15 rising edges
        base = stb_cnt;
        in_write = 1'b1;
        cs_on();
        begin
            logic [15:0] w;
            w = {1'b0, 6'd10, 1'b0, 8'h5A};
            for (int i = 15; i >= 1; i--) sbit(w[i]);
        end
        check("R3 no strobe before 16th edge", stb_cnt - base, 0);
        cs_off();
        in_write = 1'b0;
        check("R4 aborted frame strobes", stb_cnt - base, 0);
        rd_frame(6'd10, v, ok);
        cs_off();
        check("R4 aborted frame register", v, model[10]);

        // R6 R7 R8: read, then write clocks in the same window
        base = stb_cnt;
        rd_frame(6'd3, v, ok);
        check("R6 read data", v, model[3]);
        check("R6 oe during read slots", ok, 1);
        wr_frame(6'd3, 8'h77);
        check("R7 no strobe after read", stb_cnt - base, 0);
        check("R7 oe held until select rises", oe, 1);
        sel_n = 1'b1;
        tick(4 * HP);
        check("R8 oe after select high", oe, 0);
        sclk = 1'b0;
        tick(HP);
        rd_frame(6'd3, v, ok);
        cs_off();
        check("R7 register unchanged", v, model[3]);

        check("R8 oe during write frames", oe_in_write, 0);
        check("R9 strobe width", stb_long, 0);

        report();
        $finish;
    end

endmodule